// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer/Counter

This block is a down-counter paired with a companion register of the same width. A 3-bit mode input decides how the pair behaves. In the two timer reload modes the counter steps down once per qualified tick, and when it passes zero it is reloaded from the companion register. One of these modes also flips a pin output on each pass through zero. In the two external event modes the counter steps down on a chosen edge of an input pin, and it reloads in the same way. In the two capture modes the counter runs on ticks, and a chosen pin edge copies the live count into the companion register.

Software loads and reads both the counter and the companion register one byte at a time. A run input gates every counting and capture action. The pin input passes through a synchronizer and an edge detector before use. A sticky interrupt flag records each underflow in the reload modes and each capture event in the capture modes. The flag stays set until software pulses the clear input.

Top module: `tmr16_unit`

## Requirements
- R1: The counter and the companion register are each CNT_W (16) bits wide. Each byte is written on its own through wr_sel: 0 is counter low, 1 is counter high, 2 is register low, 3 is register high. A write changes only the byte it selects. rd_sel uses the same map, and rd_data shows the selected byte one clock after it is selected.
- R2: After synchronous reset the counter, the register, rd_data, irq and pin_out are all zero.
- R3: In modes 100, 101, 110 and 111 the counter drops by one on every clock where run and tick_en are both 1. It holds when either of them is 0. With run at 0 the counter never changes, except by a write.
- R4: In modes 000, 001, 100 and 101, a step taken while the counter is zero loads the register value in place of 0xFFFF and sets irq.
- R5: Modes 000 and 001 step on a rising or falling pin_in edge respectively while run is 1, and they ignore tick_en. A pin_in change sampled at clock edge k takes effect at edge k+2.
- R6: In mode 101 pin_out inverts on every underflow. In every other mode pin_out holds its value.
- R7: In modes 110 and 111, a rising or falling pin_in edge respectively, while run is 1, copies the counter value present before that clock edge into the register and sets irq. Edges of the other polarity do nothing. In these modes a step from zero wraps the counter to 0xFFFF, with no reload and no irq.
- R8: irq stays at 1 until irq_clr is pulsed. When a new event and irq_clr fall in the same cycle, the event wins.
- R9: Modes 010 and 011 freeze the counter, never set irq and leave pin_out unchanged.
- R10: A clock that writes a counter byte takes no step and no reload, and it raises no underflow. The byte that is not written keeps its value. A clock that writes a register byte cancels any capture in that clock, although irq still sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Mode select |
| run | input | 1 | Enables counting and capture |
| tick_en | input | 1 | Instruction-cycle tick qualifier |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | SEL_W (2) | Byte select for writes |
| wr_data | input | BYTE_W (8) | Write data |
| rd_sel | input | SEL_W (2) | Byte select for reads |
| rd_data | output | BYTE_W (8) | Registered read data |
| pin_in | input | 1 | Asynchronous event/capture pin |
| pin_out | output | 1 | Toggle output |
| irq_clr | input | 1 | Write-one-to-clear for irq |
| irq | output | 1 | Sticky interrupt request |

## Verification
The bench builds the block with its defaults: CNT_W 16, BYTE_W 8 and two synchronizer stages. It keeps the start and reload values small so that zero crossings come within a few ticks. It sweeps every combination of start value, reload value and tick count in both timer reload modes. The expected count, the number of underflows and the parity of pin_out are computed in closed form. Pulse-count sweeps over both event polarities, capture at several offsets with each edge polarity, and single-cycle collisions between writes and events reach the latency, wrap and priority corners.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [2:0] {
    MD_EVT_RISE = 3'b000,
    MD_EVT_FALL = 3'b001,
    MD_RSV_A    = 3'b010,
    MD_RSV_B    = 3'b011,
    MD_TMR_RLD  = 3'b100,
    MD_TMR_TGL  = 3'b101,
    MD_CAP_RISE = 3'b110,
    MD_CAP_FALL = 3'b111
  } tmr_mode_e;

  typedef struct packed {
    logic step;   // decrement this cycle
    logic uflow;  // reload from companion register
    logic tgl;    // invert pin output
  } tmr_evt_t;

endpackage

// File: rtl/tmr16_pin_edge.sv
module tmr16_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[SYNC_STAGES-1:0], pin_i};
  end

  assign rise_o = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
  assign fall_o = ~shreg[SYNC_STAGES-1] & shreg[SYNC_STAGES];

endmodule

// File: rtl/tmr16_ctl.sv
module tmr16_ctl
  import tmr16_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       cnt_zero_i,
  input  logic       cnt_wr_i,
  input  logic       rld_wr_i,
  output tmr_evt_t   evt_o,
  output logic       cap_load_o,
  output logic       irq_set_o
);

  logic step_raw, auto_rld, tgl_mode, cap_raw;

  always_comb begin
    step_raw = 1'b0;
    auto_rld = 1'b0;
    tgl_mode = 1'b0;
    cap_raw  = 1'b0;
    case (tmr_mode_e'(mode_i))
      MD_EVT_RISE: begin step_raw = run_i & rise_i; auto_rld = 1'b1; end
      MD_EVT_FALL: begin step_raw = run_i & fall_i; auto_rld = 1'b1; end
      MD_TMR_RLD:  begin step_raw = run_i & tick_i; auto_rld = 1'b1; end
      MD_TMR_TGL:  begin step_raw = run_i & tick_i; auto_rld = 1'b1; tgl_mode = 1'b1; end
      MD_CAP_RISE: begin step_raw = run_i & tick_i; cap_raw = run_i & rise_i; end
      MD_CAP_FALL: begin step_raw = run_i & tick_i; cap_raw = run_i & fall_i; end
      default: ;
    endcase
  end

  always_comb begin
    evt_o.step  = step_raw & ~cnt_wr_i;
    evt_o.uflow = evt_o.step & cnt_zero_i & auto_rld;
    evt_o.tgl   = evt_o.uflow & tgl_mode;
    cap_load_o  = cap_raw & ~rld_wr_i;
    irq_set_o   = evt_o.uflow | cap_raw;
  end

endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NB    = CNT_W / BYTE_W,
  localparam int SEL_W = $clog2(2 * NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  tmr_evt_t          evt_i,
  input  logic              cap_load_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  rld_o,
  output logic              cnt_zero_o,
  output logic              cnt_wr_o,
  output logic              rld_wr_o
);

  logic [CNT_W-1:0] cnt_q, rld_q, cnt_auto, rld_auto, cnt_d, rld_d;

  assign cnt_wr_o   = wr_en_i & (wr_sel_i <  SEL_W'(NB));
  assign rld_wr_o   = wr_en_i & (wr_sel_i >= SEL_W'(NB));
  assign cnt_zero_o = (cnt_q == '0);

  always_comb begin
    if (evt_i.uflow)     cnt_auto = rld_q;
    else if (evt_i.step) cnt_auto = cnt_q - CNT_W'(1);
    else                 cnt_auto = cnt_q;
    rld_auto = cap_load_i ? cnt_q : rld_q;
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign cnt_d[b*BYTE_W +: BYTE_W] = (wr_en_i && wr_sel_i == SEL_W'(b))
                                       ? wr_data_i : cnt_auto[b*BYTE_W +: BYTE_W];
    assign rld_d[b*BYTE_W +: BYTE_W] = (wr_en_i && wr_sel_i == SEL_W'(b + NB))
                                       ? wr_data_i : rld_auto[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;

endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
  import tmr16_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NB         = CNT_W / BYTE_W,
  localparam int SEL_W      = $clog2(2 * NB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic              run,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              pin_in,
  output logic              pin_out,
  input  logic              irq_clr,
  output logic              irq
);

  logic             pin_rise, pin_fall;
  logic             cnt_zero, cnt_wr, rld_wr, cap_load, irq_set;
  tmr_evt_t         evt;
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic [2*CNT_W-1:0] all_bytes;

  tmr16_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin_i(pin_in), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  tmr16_ctl u_ctl (
    .mode_i(mode), .run_i(run), .tick_i(tick_en), .rise_i(pin_rise),
    .fall_i(pin_fall), .cnt_zero_i(cnt_zero), .cnt_wr_i(cnt_wr),
    .rld_wr_i(rld_wr), .evt_o(evt), .cap_load_o(cap_load), .irq_set_o(irq_set)
  );

  tmr16_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .evt_i(evt), .cap_load_i(cap_load),
    .cnt_o(cnt_q), .rld_o(rld_q), .cnt_zero_o(cnt_zero),
    .cnt_wr_o(cnt_wr), .rld_wr_o(rld_wr)
  );

  assign all_bytes = {rld_q, cnt_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
      pin_out <= 1'b0;
    end else begin
      rd_data <= all_bytes[rd_sel*BYTE_W +: BYTE_W];
      if (irq_set)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
      if (evt.tgl) pin_out <= ~pin_out;
    end
  end

endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 2,
  parameter int NB    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       mode,
  input logic             run,
  input logic             tick_en,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic             irq_clr,
  input logic             irq,
  input logic             pin_out,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] rld_q,
  input logic             rise,
  input logic             fall
);

  logic cw, rw;
  assign cw = wr_en && (wr_sel <  SEL_W'(NB));
  assign rw = wr_en && (wr_sel >= SEL_W'(NB));

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (mode[2] && run && tick_en && cnt_q != '0 && !cw)
      |=> cnt_q == $past(cnt_q) - {{(CNT_W-1){1'b0}}, 1'b1});

  a_r3_idle: assert property (@(posedge clk) disable iff (rst)
    (!run && !cw) |=> $stable(cnt_q));

  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (mode[2:1] == 2'b10 && run && tick_en && cnt_q == '0 && !cw)
      |=> (cnt_q == $past(rld_q) && irq));

  a_r6_pin_hold: assert property (@(posedge clk) disable iff (rst)
    (mode != 3'b101) |=> $stable(pin_out));

  a_r7_cap_rise: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b110 && run && rise && !rw) |=> (rld_q == $past(cnt_q) && irq));

  a_r7_cap_fall: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b111 && run && fall && !rw) |=> (rld_q == $past(cnt_q) && irq));

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
    (mode[2:1] == 2'b01 && !cw) |=> $stable(cnt_q));

  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode[2:1] == 2'b01 && !irq) |=> !irq);

endmodule

bind tmr16_unit tmr16_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W), .NB(NB)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .run(run), .tick_en(tick_en),
  .wr_en(wr_en), .wr_sel(wr_sel), .irq_clr(irq_clr), .irq(irq),
  .pin_out(pin_out), .cnt_q(cnt_q), .rld_q(rld_q), .rise(pin_rise), .fall(pin_fall)
);

// File: tb/tmr16_unit_bench.sv
module tmr16_unit_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode = 3'b100;
  logic       run = 1'b0, tick_en = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic       pin_in = 1'b0, pin_out, irq_clr = 1'b0, irq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr16_unit u_tmr16_unit (
    .clk(clk), .rst(rst), .mode(mode), .run(run), .tick_en(tick_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
    .irq_clr(irq_clr), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd16(input bit reg_side, output int v);
    logic [7:0] lo;
    rd_sel = reg_side ? 2'd2 : 2'd0; tick(1); lo = rd_data;
    rd_sel = reg_side ? 2'd3 : 2'd1; tick(1);
    v = {16'h0, rd_data, lo};
  endtask

  task automatic set_cnt(input logic [15:0] v); wr(2'd0, v[7:0]); wr(2'd1, v[15:8]); endtask
  task automatic set_rld(input logic [15:0] v); wr(2'd2, v[7:0]); wr(2'd3, v[15:8]); endtask
  task automatic clr_irq(); irq_clr = 1'b1; tick(1); irq_clr = 1'b0; endtask

  function automatic int exp_val(int c, int r, int t);
    if (t <= c) return c - t;
    return r - ((t - c - 1) % (r + 1));
  endfunction

  function automatic int exp_uf(int c, int r, int t);
    if (t <= c) return 0;
    return 1 + (t - c - 1) / (r + 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v, p0, uf, cnt;
    @(negedge clk);
    tick(3);
    rst = 1'b0;

    // R2: reset state
    chk("R2 rd_data", rd_data, 0);
    chk("R2 irq", irq, 0);
    chk("R2 pin_out", pin_out, 0);
    rd16(0, v); chk("R2 counter", v, 0);
    rd16(1, v); chk("R2 register", v, 0);

    // R1: byte access
    set_cnt(16'h1234); set_rld(16'hABCD);
    rd16(0, v); chk("R1 counter", v, 16'h1234);
    rd16(1, v); chk("R1 register", v, 16'hABCD);
    wr(2'd1, 8'h5A); rd16(0, v); chk("R1 counter hi only", v, 16'h5A34);
    wr(2'd2, 8'h00); rd16(1, v); chk("R1 register lo only", v, 16'hAB00);

    // R3: tick gating
    mode = 3'b100; set_cnt(16'h0100); cnt = 0;
    run = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tick_en = (i % 3 != 0); if (tick_en) cnt++;
      tick(1);
    end
    tick_en = 1'b0; run = 1'b0;
    rd16(0, v); chk("R3 gated count", v, 16'h0100 - cnt);
    tick_en = 1'b1; tick(10); tick_en = 1'b0;
    rd16(0, v); chk("R3 hold when stopped", v, 16'h0100 - cnt);

    // R4 / R6: reload sweep in both timer reload modes
    for (int m = 0; m < 2; m++) begin
      for (int r = 0; r < 5; r++) for (int c = 0; c < 4; c++) for (int t = 0; t < 10; t++) begin
        mode = (m == 0) ? 3'b100 : 3'b101;
        set_cnt(16'(c)); set_rld(16'(r)); clr_irq();
        p0 = pin_out;
        if (t > 0) begin run = 1'b1; tick_en = 1'b1; tick(t); run = 1'b0; tick_en = 1'b0; end
        uf = exp_uf(c, r, t);
        rd16(0, v); chk($sformatf("R4 count m%0d c%0d r%0d t%0d", m, c, r, t), v, exp_val(c, r, t));
        chk("R4 irq", irq, (uf > 0) ? 1 : 0);
        chk("R6 pin_out", pin_out, (m == 1) ? (p0 ^ (uf & 1)) : p0);
      end
    end

    // R5: external edge counting, both polarities, tick_en ignored
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 7; n++) begin
        mode = (m == 0) ? 3'b000 : 3'b001;
        set_cnt(16'(n % 3)); set_rld(16'(1 + 2 * m)); clr_irq();
        pin_in = 1'b0; tick(4);
        run = 1'b1; tick_en = 1'b1;
        for (int k = 0; k < n; k++) begin pin_in = 1'b1; tick(3); pin_in = 1'b0; tick(3); end
        if (m == 1) begin pin_in = 1'b1; tick(4); end
        tick(4); run = 1'b0; tick_en = 1'b0;
        pin_in = 1'b0; tick(4);
        uf = exp_uf(n % 3, 1 + 2 * m, n);
        rd16(0, v); chk($sformatf("R5 edges m%0d n%0d", m, n), v, exp_val(n % 3, 1 + 2 * m, n));
        chk("R5 irq", irq, (uf > 0) ? 1 : 0);
      end
    end

    // R5: latency of a pin edge
    mode = 3'b000; set_cnt(16'h0000); set_rld(16'h0007); clr_irq();
    pin_in = 1'b0; tick(4); run = 1'b1;
    pin_in = 1'b1;
    tick(1); chk("R5 latency k", irq, 0);
    tick(1); chk("R5 latency k+1", irq, 0);
    tick(1); chk("R5 latency k+2", irq, 1);
    run = 1'b0; pin_in = 1'b0; tick(4);
    rd16(0, v); chk("R5 reload on edge", v, 7);

    // R7: capture at several offsets, both polarities
    for (int m = 0; m < 2; m++) begin
      for (int a = 2; a < 8; a++) begin
        mode = (m == 0) ? 3'b110 : 3'b111;
        set_cnt(16'h0050); set_rld(16'h1111); clr_irq();
        pin_in = (m == 1); tick(4);
        run = 1'b1; tick_en = 1'b1;
        tick(a); pin_in = ~pin_in; tick(6);
        run = 1'b0; tick_en = 1'b0;
        rd16(1, v); chk($sformatf("R7 capture m%0d a%0d", m, a), v, 16'h0050 - (a + 2));
        rd16(0, v); chk("R7 counter keeps running", v, 16'h0050 - (a + 6));
        chk("R7 irq on capture", irq, 1);
      end
      // wrong polarity does nothing
      set_cnt(16'h0050); set_rld(16'h1111); clr_irq();
      pin_in = (m == 0); tick(4);
      run = 1'b1; pin_in = ~pin_in; tick(6); run = 1'b0;
      rd16(1, v); chk("R7 other edge ignored", v, 16'h1111);
      chk("R7 other edge no irq", irq, 0);
    end
    pin_in = 1'b0; tick(4);

    // R7: wrap with no reload in capture mode
    mode = 3'b110; set_cnt(16'h0001); set_rld(16'h1111); clr_irq();
    run = 1'b1; tick_en = 1'b1; tick(3); run = 1'b0; tick_en = 1'b0;
    rd16(0, v); chk("R7 wrap", v, 16'hFFFE);
    rd16(1, v); chk("R7 wrap register untouched", v, 16'h1111);
    chk("R7 wrap no irq", irq, 0);

    // R8: sticky flag and set-over-clear
    mode = 3'b100; set_cnt(16'h0000); set_rld(16'h0009); clr_irq();
    run = 1'b1; tick_en = 1'b1; irq_clr = 1'b1; tick(1);
    run = 1'b0; tick_en = 1'b0; irq_clr = 1'b0;
    chk("R8 set beats clear", irq, 1);
    tick(5); chk("R8 sticky", irq, 1);
    clr_irq(); chk("R8 cleared", irq, 0);

    // R9: reserved modes freeze everything
    for (int m = 0; m < 2; m++) begin
      mode = (m == 0) ? 3'b010 : 3'b011;
      set_cnt(16'h0000); set_rld(16'h0004); clr_irq();
      p0 = pin_out;
      run = 1'b1; tick_en = 1'b1;
      for (int k = 0; k < 3; k++) begin pin_in = 1'b1; tick(3); pin_in = 1'b0; tick(3); end
      run = 1'b0; tick_en = 1'b0;
      rd16(0, v); chk("R9 frozen counter", v, 0);
      chk("R9 no irq", irq, 0);
      chk("R9 pin_out held", pin_out, p0);
    end

    // R10: counter write beats step and reload
    mode = 3'b100; set_cnt(16'h0000); set_rld(16'h0055); clr_irq();
    run = 1'b1; tick_en = 1'b1; wr(2'd1, 8'h12); run = 1'b0; tick_en = 1'b0;
    rd16(0, v); chk("R10 write beats reload", v, 16'h1200);
    chk("R10 no underflow irq", irq, 0);

    // R10: register write cancels capture, irq still set
    mode = 3'b110; set_cnt(16'h0050); set_rld(16'h1111); clr_irq();
    pin_in = 1'b0; tick(4);
    run = 1'b1; tick_en = 1'b1;
    pin_in = 1'b1; tick(2); wr(2'd2, 8'h77);
    run = 1'b0; tick_en = 1'b0;
    rd16(1, v); chk("R10 write beats capture", v, 16'h1177);
    chk("R10 capture irq", irq, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule